// File: doc/BRIEF.md
# ADC bus strobe stretcher

This block turns short CPU bus events into long, clock-counted strobes for a slow ADC. It does this with shift chains instead of analog one-shots. A bus write request (active low) clears a write-timing chain. The chain refills with ones from its serial input, and its last stage forms the active-low write strobe. That strobe stays low until the configured number of step edges has passed.

The ADC's active-low conversion-done interrupt is asynchronous. It passes through a two-flop synchronizer into a second chain, which acts as a delay line. The last stage of that chain drives the active-low read strobe, which also serves as the output enable of the data latch. Once the delayed interrupt pulls the read line low, the ADC releases its interrupt. That release travels through the same path, so the width of the read strobe is set by the loop delay.

A step enable sets the chain rate. Tying it high steps the chains once per bus clock. Pulsing it from a slower source, such as the ADC's own clock, stretches both strobes.

Top module: `adc_strobe_stretch`

## Requirements
- R1: While reset is asserted, and right after it is released, both `wr_strobe_n` and `rd_strobe_n` are high.
- R2: If `wr_req_n` is low at a rising clock edge, `wr_strobe_n` is low after that edge. This holds whatever the state of `step_en`.
- R3: After the last edge at which `wr_req_n` was low, `wr_strobe_n` stays low until STAGES (4) edges with `step_en` high have passed. It then goes high and stays high.
- R4: A write request during an active write strobe restarts the full low period. Two single-cycle requests two cycles apart, at full rate, give a low period of 6 cycles.
- R5: A clear takes priority over a shift in the same cycle, including when `step_en` is high.
- R6: `rd_strobe_n` after an edge equals the `conv_done_n` value sampled at the edge two cycles before the STAGES-th most recent enabled edge. It is high if fewer than STAGES enabled edges have occurred since reset.
- R7: On edges with `step_en` low, neither strobe changes, apart from a clear by a write request.
- R8: With `step_en` held high and an ADC that releases its interrupt one cycle after seeing the read strobe low, the read strobe is low for exactly 6 cycles, which is more than 3. A single write request gives a write strobe exactly 4 cycles long.
- R9: With `step_en` high on every third cycle, a single write request gives a write strobe at least 10 cycles long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Chain step enable |
| wr_req_n | input | 1 | Active-low bus write request (clears the write chain) |
| conv_done_n | input | 1 | Asynchronous active-low conversion-done from the ADC |
| wr_strobe_n | output | 1 | Active-low write strobe to the ADC |
| rd_strobe_n | output | 1 | Active-low read strobe and latch output enable |

## Verification
The bench sweeps step-enable divisors from 1 to 4. At every divisor it places a write request at each phase offset relative to the enable pulse. This separates a clear that waits for an enabled edge from one that acts at once. It also separates counting all clock edges from counting only enabled ones. Conversion-done events run through a closed-loop ADC model, which shows whether the read strobe's width comes from the synchronizer-plus-delay loop rather than from a fixed count. Back-to-back and held write requests separate a restart from a strobe that ignores a new request. Long stretches with the enable low confirm that both strobes stay frozen.

// File: rtl/adc_strobe_stretch.sv
module adc_strobe_stretch #(
  parameter int STAGES      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_en,
  input  logic wr_req_n,
  input  logic conv_done_n,
  output logic wr_strobe_n,
  output logic rd_strobe_n
);

  logic [STAGES-1:0]      wchain;
  logic [STAGES-1:0]      rchain;
  logic [SYNC_STAGES-1:0] sync;

  wire wr_clear = ~wr_req_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wchain <= '1;
    else if (wr_clear) wchain <= '0;
    else if (step_en)  wchain <= {wchain[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[SYNC_STAGES-2:0], conv_done_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rchain <= '1;
    else if (step_en) rchain <= {rchain[STAGES-2:0], sync[SYNC_STAGES-1]};
  end

  assign wr_strobe_n = wchain[STAGES-1];
  assign rd_strobe_n = rchain[STAGES-1];

endmodule

// File: rtl/adc_strobe_stretch_chk.sv
module adc_strobe_stretch_chk #(
  parameter int STAGES = 4
) (
  input logic clk,
  input logic rst_n,
  input logic step_en,
  input logic wr_req_n,
  input logic conv_done_n,
  input logic wr_strobe_n,
  input logic rd_strobe_n
);

  localparam int CW = $clog2(STAGES + 1);
  logic [CW-1:0] steps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  steps <= CW'(STAGES);
    else if (!wr_req_n)                          steps <= '0;
    else if (step_en && steps != CW'(STAGES))    steps <= steps + 1'b1;
  end

  a_r1_reset_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (wr_strobe_n && rd_strobe_n));

  a_r2_clear_drops_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_req_n |=> !wr_strobe_n);

  a_r3_width_by_steps: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_n == (steps == CW'(STAGES)));

  a_r7_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req_n && !step_en) |=> $stable(wr_strobe_n));

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> $stable(rd_strobe_n));

endmodule

bind adc_strobe_stretch adc_strobe_stretch_chk #(.STAGES(STAGES)) u_chk (.*);

// File: tb/adc_strobe_stretch_test.sv
module adc_strobe_stretch_test;
  localparam int S = 4;

  logic clk = 0, rst_n = 0, step_en = 0, wr_req_n = 1, conv_done_n = 1;
  logic wr_strobe_n, rd_strobe_n;
  int checks = 0, errors = 0;
  bit finished = 0;

  int div = 1, ph = 0;
  int wcnt = S;
  logic dm1 = 1, dm2 = 1;
  logic [S-1:0] rq = '1;
  int wlow = 0, rlow = 0, last_wlow = 0, last_rlow = 0;

  always #4 clk = ~clk;

  adc_strobe_stretch uut (.*);

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (!wr_req_n) wcnt = 0;
    else if (step_en && wcnt < S) wcnt++;
    if (step_en) rq = {rq[S-2:0], dm2};
    dm2 = dm1;
    dm1 = conv_done_n;
    @(negedge clk);
    chk("R3 write strobe", wr_strobe_n, wcnt >= S);
    chk("R6 read delay", rd_strobe_n, rq[S-1]);
    if (!wr_strobe_n) wlow++; else if (wlow > 0) begin last_wlow = wlow; wlow = 0; end
    if (!rd_strobe_n) rlow++; else if (rlow > 0) begin last_rlow = rlow; rlow = 0; end
    if (!rd_strobe_n) conv_done_n = 1;
    ph++;
    step_en = (div != 0) && (ph % div == 0);
  endtask

  task automatic do_write(int len);
    wr_req_n = 0;
    for (int i = 0; i < len; i++) tick();
    wr_req_n = 1;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset wr", wr_strobe_n, 1'b1);
    chk("R1 reset rd", rd_strobe_n, 1'b1);
    rst_n = 1;
    step_en = 1;
    div = 1;
    tick();
    chk("R1 after release", wr_strobe_n & rd_strobe_n, 1'b1);

    do_write(1);
    chk("R2 clear", wr_strobe_n, 1'b0);
    repeat (8) tick();
    chk_int("R8 write width", last_wlow, 4);

    do_write(1); tick(); do_write(1);
    repeat (10) tick();
    chk_int("R4 restart width", last_wlow, 6);

    do_write(3);
    repeat (10) tick();
    chk_int("R5 held clear width", last_wlow, 6);

    conv_done_n = 0;
    repeat (20) tick();
    chk_int("R8 read width", last_rlow, 6);
    chk("R8 read wider than 3", last_rlow > 3, 1'b1);

    div = 0; step_en = 0;
    tick();
    do_write(1);
    chk("R5 clear without step", wr_strobe_n, 1'b0);
    repeat (6) tick();
    chk("R7 wr frozen", wr_strobe_n, 1'b0);
    conv_done_n = 0;
    repeat (6) tick();
    chk("R7 rd frozen", rd_strobe_n, 1'b1);
    div = 1; step_en = 1;
    repeat (30) tick();

    for (int d = 1; d <= 4; d++) begin
      div = d;
      for (int off = 0; off < d; off++) begin
        while (ph % d != off) tick();
        do_write(1);
        repeat (6 * d + 6) tick();
        if (d == 3) chk("R9 slow write width", last_wlow >= 10, 1'b1);
        conv_done_n = 0;
        repeat (16 * d + 12) tick();
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule